// File: doc/BRIEF.md
# Polling Compare-and-Wait Engine

This block carries out a wait command inside a command-processing pipeline. The command is fed in one 32-bit word per accepted handshake. It names a source, a reference and a mask. The source is a 64-bit memory address, one of eight scratch registers, or a control register.

After the last word arrives, the engine reads the source. It ANDs the value with the mask and compares the result with the reference, using the selected function. The comparison is signed or unsigned as the command chooses. If the comparison fails, the engine waits for the programmed number of idle cycles and reads again.

Command intake stays closed until the comparison succeeds. The engine then pulses done and becomes ready for the next command at once.

A second, shorter command form is selected by a side-band flag that comes with the first word. It always polls memory for a signed greater-or-equal against the reference, with no mask and no back-off.

Top module: `poll_wait_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0, cmd_ready_o is 1, and neither mem_req_valid_o nor reg_rd_en_o is asserted.
- R2: A six-word command has word 0 as the mode word, then the address low word, the address high word, the reference, the mask and the back-off count. With mode bit 4 set, each poll raises mem_req_valid_o for one cycle with mem_req_addr_o = {high word, low word}.
- R3: With mode bit 5 set and bit 4 clear, each poll reads scratch entry number (low word bits 2:0), taken from scratch_i bits [32*n +: 32]. No memory request or register read is issued.
- R4: With mode bits 4 and 5 both clear, each poll raises reg_rd_en_o for one cycle with reg_rd_addr_o = low word bits 17:0. The data on reg_rd_data_i in the following cycle is used.
- R5: Mode bits 2:0 select the test of (sample AND mask) against the reference:
  - 0 and 7: always true
  - 1: less-than
  - 2: less-or-equal
  - 3: equal
  - 4: not-equal
  - 5: greater-or-equal
  - 6: greater-than
- R6: Mode bit 3 set makes the ordering tests signed (two's complement); clear makes them unsigned.
- R7: When a test fails with back-off count N, the next memory or register request starts N+3 cycles after the previous one. This assumes a response one cycle after the request. No request is made during the back-off.
- R8: A back-off count of 0 re-polls in the cycle after the failing test, giving a request spacing of 3 cycles.
- R9: done_o is high for exactly one cycle after the first passing test, and busy_o is 0 in that cycle. A new command may begin in that cycle.
- R10: When cmd_short_i is 1 with word 0, the command is four words long: an ignored word, the address low word, the address high word and the reference. Its mode bits are ignored. It polls memory with a signed greater-or-equal test, an all-ones mask and a back-off of 0.
- R11: With mode bits 4 and 5 both set, memory is polled.
- R12: While a command is executing (after its last word until done), cmd_ready_o is 0. Words offered in that time are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Command word offered |
| cmd_ready_o | output | 1 | Engine accepts a command word this cycle |
| cmd_word_i | input | 32 | Command word |
| cmd_short_i | input | 1 | With word 0: selects the four-word form |
| mem_req_valid_o | output | 1 | One-cycle memory read request |
| mem_req_addr_o | output | 64 | Memory read address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | 32 | Memory read data |
| scratch_i | input | 256 | Eight 32-bit scratch registers, entry n at [32*n +: 32] |
| reg_rd_en_o | output | 1 | One-cycle register read strobe |
| reg_rd_addr_o | output | 18 | Register read address |
| reg_rd_data_i | input | 32 | Register read data, valid the cycle after the strobe |
| busy_o | output | 1 | A command is being collected or executed |
| done_o | output | 1 | One-cycle pulse when the wait condition is met |

## Verification
The assertions rely on the following input behaviour:
- Exactly one memory response arrives for each request, and never without one.
- Register data is valid in the cycle after the strobe.
- Command words are taken only when cmd_ready_o is high.

The stimulus stays within these limits. Its memory and register models answer every request exactly one cycle later, from a per-command list of values. The command driver offers a word only after it has seen ready high away from the clock edge. Junk words are offered only during an execution phase, to show that they are refused.

// File: rtl/pw_pkg.sv
// Package: shared types and header field positions for the polling wait engine.
// Assumes a 32-bit command word; positions below are the mode-word layout.
package pw_pkg;

    typedef enum logic [2:0] {
        CMP_ALWAYS = 3'd0,
        CMP_LT     = 3'd1,
        CMP_LE     = 3'd2,
        CMP_EQ     = 3'd3,
        CMP_NE     = 3'd4,
        CMP_GE     = 3'd5,
        CMP_GT     = 3'd6,
        CMP_ALWAYS_ALT = 3'd7
    } cmp_fn_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_MEM = 2'd1,
        SRC_SCR = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_COLLECT = 3'd1,
        S_ISSUE   = 3'd2,
        S_WMEM    = 3'd3,
        S_WREG    = 3'd4,
        S_EVAL    = 3'd5,
        S_DELAY   = 3'd6
    } state_e;

    typedef struct packed {
        cmp_fn_e fn;
        logic    is_signed;
        src_e    src;
    } mode_t;

    localparam int FN_LSB     = 0;
    localparam int SIGNED_BIT = 3;
    localparam int MEM_BIT    = 4;
    localparam int SCR_BIT    = 5;

    localparam int IDX_LO    = 1;
    localparam int IDX_HI    = 2;
    localparam int IDX_REF   = 3;
    localparam int IDX_MASK  = 4;
    localparam int IDX_DELAY = 5;
    localparam int LAST_LONG  = 5;
    localparam int LAST_SHORT = 3;

endpackage

// File: rtl/pw_cmd_capture.sv
// Module: collects the words of one wait command into field registers.
// Assumes word_valid_i is only high when the top accepts a word; word 0 is
// the mode word (or an ignored word in the short form, chosen by short_i).
module pw_cmd_capture
    import pw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              short_i,
    output mode_t             mode_o,
    output logic [DATA_W-1:0] addr_lo_o,
    output logic [DATA_W-1:0] addr_hi_o,
    output logic [DATA_W-1:0] ref_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] delay_o,
    output logic              last_o
);

    localparam int IDX_W = 3;

    logic [IDX_W-1:0] idx_q;
    logic             short_q;
    logic [IDX_W-1:0] last_idx;

    // Last word index of the command currently being collected.
    always_comb begin
        last_idx = short_q ? IDX_W'(LAST_SHORT) : IDX_W'(LAST_LONG);
    end

    // A word completing the command (word 0 is never last).
    always_comb begin
        last_o = word_valid_i && (idx_q != '0) && (idx_q == last_idx);
    end

    // Word counter: advances per accepted word, wraps after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (word_valid_i) begin
            if (last_o) idx_q <= '0;
            else        idx_q <= idx_q + 1'b1;
        end
    end

    // Field capture: decode mode from word 0, store payload by position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_q   <= 1'b0;
            mode_o    <= '{fn: CMP_ALWAYS, is_signed: 1'b0, src: SRC_REG};
            addr_lo_o <= '0;
            addr_hi_o <= '0;
            ref_o     <= '0;
            mask_o    <= '0;
            delay_o   <= '0;
        end else if (word_valid_i) begin
            if (idx_q == '0) begin
                short_q <= short_i;
                if (short_i) begin
                    mode_o  <= '{fn: CMP_GE, is_signed: 1'b1, src: SRC_MEM};
                    mask_o  <= '1;
                    delay_o <= '0;
                end else begin
                    mode_o.fn        <= cmp_fn_e'(word_i[FN_LSB +: 3]);
                    mode_o.is_signed <= word_i[SIGNED_BIT];
                    if (word_i[MEM_BIT])      mode_o.src <= SRC_MEM;
                    else if (word_i[SCR_BIT]) mode_o.src <= SRC_SCR;
                    else                      mode_o.src <= SRC_REG;
                end
            end else begin
                case (int'(idx_q))
                    IDX_LO:    addr_lo_o <= word_i;
                    IDX_HI:    addr_hi_o <= word_i;
                    IDX_REF:   ref_o     <= word_i;
                    IDX_MASK:  mask_o    <= word_i;
                    IDX_DELAY: delay_o   <= word_i;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pw_compare.sv
// Module: masked comparison of a polled sample against a reference.
// Purely combinational; the mask applies to the sample only.
module pw_compare
    import pw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cmp_fn_e           fn_i,
    input  logic              signed_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] ref_i,
    output logic              pass_o
);

    logic [DATA_W-1:0] masked;
    logic              lt;
    logic              eq;

    // Ordering and equality of the masked sample versus the reference.
    always_comb begin
        masked = sample_i & mask_i;
        eq     = (masked == ref_i);
        if (signed_i) lt = ($signed(masked) < $signed(ref_i));
        else          lt = (masked < ref_i);
    end

    // Function select.
    always_comb begin
        case (fn_i)
            CMP_LT:  pass_o = lt;
            CMP_LE:  pass_o = lt || eq;
            CMP_EQ:  pass_o = eq;
            CMP_NE:  pass_o = !eq;
            CMP_GE:  pass_o = !lt;
            CMP_GT:  pass_o = !lt && !eq;
            default: pass_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pw_delay.sv
// Module: back-off down-counter between polls.
// Assumes load_i is only raised with a non-zero value while the counter is idle.
module pw_delay #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             active_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Counter: loads the back-off, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load_i)          cnt_q <= load_val_i;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    // Status: running while non-zero, expiring on its final cycle.
    always_comb begin
        active_o = (cnt_q != '0);
        expire_o = (cnt_q == CNT_W'(1));
    end

    // R7
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !active_o);

    // R7
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/poll_wait_engine.sv
// Module: top of the polling compare-and-wait engine.
// Collects a wait command, polls memory, scratch or a register until the
// masked comparison passes, backing off between polls. Assumes one memory
// response per request and register data one cycle after the strobe.
module poll_wait_engine
    import pw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SCR_N  = 8,
    parameter int REG_AW = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid_i,
    output logic                    cmd_ready_o,
    input  logic [DATA_W-1:0]       cmd_word_i,
    input  logic                    cmd_short_i,
    output logic                    mem_req_valid_o,
    output logic [2*DATA_W-1:0]     mem_req_addr_o,
    input  logic                    mem_rsp_valid_i,
    input  logic [DATA_W-1:0]       mem_rsp_data_i,
    input  logic [SCR_N*DATA_W-1:0] scratch_i,
    output logic                    reg_rd_en_o,
    output logic [REG_AW-1:0]       reg_rd_addr_o,
    input  logic [DATA_W-1:0]       reg_rd_data_i,
    output logic                    busy_o,
    output logic                    done_o
);

    localparam int SCR_IW = $clog2(SCR_N);

    state_e            state_q;
    mode_t             mode;
    logic [DATA_W-1:0] addr_lo, addr_hi, ref_w, mask_w, delay_w;
    logic              cap_last;
    logic              word_acc;
    logic [DATA_W-1:0] sample_q;
    logic              pass;
    logic              dly_load, dly_active, dly_expire;
    logic              done_q;
    logic [DATA_W-1:0] scr_sel;

    // Handshake: words are taken only while idle or collecting.
    always_comb begin
        cmd_ready_o = (state_q == S_IDLE) || (state_q == S_COLLECT);
        word_acc    = cmd_valid_i && cmd_ready_o;
    end

    pw_cmd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid_i (word_acc),
        .word_i       (cmd_word_i),
        .short_i      (cmd_short_i),
        .mode_o       (mode),
        .addr_lo_o    (addr_lo),
        .addr_hi_o    (addr_hi),
        .ref_o        (ref_w),
        .mask_o       (mask_w),
        .delay_o      (delay_w),
        .last_o       (cap_last)
    );

    pw_compare #(.DATA_W(DATA_W)) u_cmp (
        .fn_i     (mode.fn),
        .signed_i (mode.is_signed),
        .sample_i (sample_q),
        .mask_i   (mask_w),
        .ref_i    (ref_w),
        .pass_o   (pass)
    );

    // Back-off starts on a failing test with a non-zero count.
    always_comb begin
        dly_load = (state_q == S_EVAL) && !pass && (delay_w != '0);
    end

    pw_delay #(.CNT_W(DATA_W)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (dly_load),
        .load_val_i (delay_w),
        .active_o   (dly_active),
        .expire_o   (dly_expire)
    );

    // Scratch entry picked by the low address bits.
    always_comb begin
        scr_sel = scratch_i[addr_lo[SCR_IW-1:0]*DATA_W +: DATA_W];
    end

    // Sequencer: collect, issue a poll, wait for data, evaluate, back off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE:    if (word_acc) state_q <= S_COLLECT;
                S_COLLECT: if (cap_last) state_q <= S_ISSUE;
                S_ISSUE: begin
                    case (mode.src)
                        SRC_MEM: state_q <= S_WMEM;
                        SRC_SCR: state_q <= S_EVAL;
                        default: state_q <= S_WREG;
                    endcase
                end
                S_WMEM:    if (mem_rsp_valid_i) state_q <= S_EVAL;
                S_WREG:    state_q <= S_EVAL;
                S_EVAL: begin
                    if (pass)                 state_q <= S_IDLE;
                    else if (delay_w == '0)   state_q <= S_ISSUE;
                    else                      state_q <= S_DELAY;
                end
                S_DELAY:   if (dly_expire) state_q <= S_ISSUE;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    // Sample register: takes data from whichever source the poll used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
        end else begin
            if (state_q == S_ISSUE && mode.src == SRC_SCR) sample_q <= scr_sel;
            if (state_q == S_WMEM && mem_rsp_valid_i)      sample_q <= mem_rsp_data_i;
            if (state_q == S_WREG)                         sample_q <= reg_rd_data_i;
        end
    end

    // Completion pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == S_EVAL) && pass;
    end

    // Output drive.
    always_comb begin
        mem_req_valid_o = (state_q == S_ISSUE) && (mode.src == SRC_MEM);
        mem_req_addr_o  = {addr_hi, addr_lo};
        reg_rd_en_o     = (state_q == S_ISSUE) && (mode.src == SRC_REG);
        reg_rd_addr_o   = addr_lo[REG_AW-1:0];
        busy_o          = (state_q != S_IDLE);
        done_o          = done_q;
    end

    // R2
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid_o && reg_rd_en_o));

    // R12
    closed_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o || reg_rd_en_o) |-> !cmd_ready_o);

    // R7
    quiet_backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_active |-> (!mem_req_valid_o && !reg_rd_en_o));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && cmd_ready_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL && (mode.fn == CMP_ALWAYS || mode.fn == CMP_ALWAYS_ALT)) |=> done_o);

endmodule

// File: tb/tb_poll_wait_engine.sv
module tb_poll_wait_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid_i = 1'b0;
    logic         cmd_ready_o;
    logic [31:0]  cmd_word_i = '0;
    logic         cmd_short_i = 1'b0;
    logic         mem_req_valid_o;
    logic [63:0]  mem_req_addr_o;
    logic         mem_rsp_valid_i = 1'b0;
    logic [31:0]  mem_rsp_data_i = '0;
    logic [255:0] scratch_i = '0;
    logic         reg_rd_en_o;
    logic [17:0]  reg_rd_addr_o;
    logic [31:0]  reg_rd_data_i = '0;
    logic         busy_o;
    logic         done_o;

    always #4 clk = ~clk;

    poll_wait_engine dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
        .cmd_word_i(cmd_word_i), .cmd_short_i(cmd_short_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .scratch_i(scratch_i),
        .reg_rd_en_o(reg_rd_en_o), .reg_rd_addr_o(reg_rd_addr_o),
        .reg_rd_data_i(reg_rd_data_i),
        .busy_o(busy_o), .done_o(done_o)
    );

    typedef struct {
        int          polls;
        int          gap;
        int          src;   // 0 reg, 1 mem, 2 scratch
        logic [63:0] addr;
    } exp_t;

    int tests = 0;
    int fails = 0;
    exp_t sb_q[$];
    logic [31:0] resp_q[$];
    int done_cnt = 0;
    int n_req = 0;
    int last_req = 0;
    int cyc = 0;
    int ready_viol = 0;
    bit done_prev = 0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Memory and register models: answer one cycle after each request.
    always @(posedge clk) begin
        mem_rsp_valid_i <= mem_req_valid_o;
        if (mem_req_valid_o || reg_rd_en_o) begin
            logic [31:0] v;
            v = (resp_q.size() > 0) ? resp_q.pop_front() : 32'h0;
            if (mem_req_valid_o) mem_rsp_data_i <= v;
            else                 reg_rd_data_i  <= v;
        end
    end

    // Monitor: pops expectations and compares as results appear.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if ((mem_req_valid_o || reg_rd_en_o) && cmd_ready_o) ready_viol++;
            if ((mem_req_valid_o || reg_rd_en_o) && sb_q.size() > 0) begin
                n_req++;
                if (sb_q[0].src == 1) begin
                    chk(mem_req_valid_o, "R2/R11 memory source", mem_req_valid_o, 1);
                    chk(mem_req_addr_o == sb_q[0].addr, "R2 address", mem_req_addr_o, sb_q[0].addr);
                end else if (sb_q[0].src == 0) begin
                    chk(reg_rd_en_o, "R4 register source", reg_rd_en_o, 1);
                    chk(reg_rd_addr_o == sb_q[0].addr[17:0], "R4 address", reg_rd_addr_o, sb_q[0].addr[17:0]);
                end else begin
                    chk(0, "R3 no request in scratch mode", 1, 0);
                end
                if (n_req > 1)
                    chk(cyc - last_req == sb_q[0].gap, "R7/R8 poll spacing", cyc - last_req, sb_q[0].gap);
                last_req = cyc;
            end
            if (done_o) begin
                chk(!busy_o, "R9 busy low with done", busy_o, 0);
                chk(!done_prev, "R9 single pulse", done_prev, 0);
                if (sb_q.size() > 0) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(n_req == e.polls, "R5/R6 poll count", n_req, e.polls);
                end
                chk(ready_viol == 0, "R12 ready low while executing", ready_viol, 0);
                ready_viol = 0;
                n_req = 0;
                done_cnt++;
            end
            done_prev = done_o;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic bit b_pass(int fn, bit sgn, logic [31:0] v, logic [31:0] r);
        bit lt;
        lt = sgn ? ($signed(v) < $signed(r)) : (v < r);
        case (fn)
            1: return lt;
            2: return lt || v == r;
            3: return v == r;
            4: return v != r;
            5: return !lt;
            6: return !lt && v != r;
            default: return 1;
        endcase
    endfunction

    task automatic send_word(logic [31:0] w, bit sh);
        @(negedge clk);
        while (!cmd_ready_o) @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_word_i  = w;
        cmd_short_i = sh;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cmd_short_i = 1'b0;
    endtask

    // Driver: computes expected polls from the response list, then sends.
    task automatic run_cmd(bit sh, logic [31:0] w0, logic [31:0] lo, logic [31:0] hi,
                           logic [31:0] rf, logic [31:0] mk, logic [31:0] dly,
                           logic [31:0] resp[$]);
        exp_t e;
        int fn, src, start;
        bit sgn;
        logic [31:0] mask;
        if (sh) begin fn = 5; sgn = 1; src = 1; mask = '1; dly = 0; end
        else begin
            fn = int'(w0[2:0]); sgn = w0[3]; mask = mk;
            src = w0[4] ? 1 : (w0[5] ? 2 : 0);
        end
        e.polls = resp.size();
        foreach (resp[i]) if (b_pass(fn, sgn, resp[i] & mask, rf)) begin
            e.polls = i + 1; break;
        end
        e.gap = int'(dly) + 3;
        e.src = src;
        e.addr = {hi, lo};
        resp_q = resp;
        sb_q.push_back(e);
        start = done_cnt;
        send_word(w0, sh);
        send_word(lo, 0);
        send_word(hi, 0);
        send_word(rf, 0);
        if (!sh) begin
            send_word(mk, 0);
            send_word(dly, 0);
        end
        wait (done_cnt == start + 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o, "R1 busy", busy_o, 0);
        chk(!done_o, "R1 done", done_o, 0);
        chk(cmd_ready_o, "R1 ready", cmd_ready_o, 1);
        chk(!mem_req_valid_o && !reg_rd_en_o, "R1 no request", mem_req_valid_o, 0);

        // R2 R5 memory, masked equal, back-off 2
        run_cmd(0, 32'h13, 32'h1000_0040, 32'h0000_00AB, 32'h34, 32'hFF, 2,
                '{32'h1200, 32'hAB33, 32'h5634});
        // R6 signed less-than, R8 back-off 0
        run_cmd(0, 32'h19, 32'h20, 32'h1, 32'h0, 32'hFFFF_FFFF, 0,
                '{32'h5, 32'hFFFF_FFFF});
        // R6 unsigned less-than
        run_cmd(0, 32'h11, 32'h24, 32'h1, 32'h4, 32'hFFFF_FFFF, 0,
                '{32'hFFFF_FFFF, 32'h3});
        // R4 register, greater-than, back-off 1
        run_cmd(0, 32'h06, 32'h0001_2345, 32'h0, 32'h5, 32'hFFFF_FFFF, 1,
                '{32'h1, 32'h2, 32'h9});
        // R5 less-or-equal register
        run_cmd(0, 32'h02, 32'hFFFC_0010, 32'h0, 32'h5, 32'hFFFF_FFFF, 0,
                '{32'h7, 32'h3});
        // R5 not-equal memory, back-off 4
        run_cmd(0, 32'h14, 32'h80, 32'h7, 32'h5, 32'hFFFF_FFFF, 4,
                '{32'h5, 32'h5, 32'h6});
        // R10 short form: reserved word has scratch/reg bits that are ignored
        run_cmd(1, 32'h0000_0021, 32'h400, 32'h2, 32'hA, 32'h0, 0,
                '{32'h8000_0000, 32'h9, 32'hA});
        // R11 both source bits set polls memory; code 0 always true
        run_cmd(0, 32'h30, 32'h900, 32'h0, 32'h0, 32'h0, 0, '{32'h0});
        // R5 code 7 always true on register
        run_cmd(0, 32'h07, 32'h55, 32'h0, 32'hFFFF, 32'h0, 0, '{32'h1});

        // R3 scratch index 5, equal 0x77, back-off 4; R12 junk words refused
        begin
            exp_t e;
            int start;
            for (int i = 0; i < 8; i++) scratch_i[i*32 +: 32] = 32'h77;
            scratch_i[5*32 +: 32] = 32'h0;
            e.polls = 0; e.gap = 0; e.src = 2; e.addr = '0;
            sb_q.push_back(e);
            start = done_cnt;
            send_word(32'h23, 0);
            send_word(32'hFFFF_FFF5, 0);
            send_word(32'h0, 0);
            send_word(32'h77, 0);
            send_word(32'hFFFF_FFFF, 0);
            send_word(32'h4, 0);
            repeat (3) @(negedge clk);
            chk(!cmd_ready_o, "R12 ready low in wait", cmd_ready_o, 0);
            cmd_valid_i = 1'b1;
            cmd_word_i  = 32'h10;
            repeat (30) @(negedge clk);
            cmd_valid_i = 1'b0;
            chk(busy_o, "R3 still waiting on scratch entry 5", busy_o, 1);
            chk(done_cnt == start, "R3 no early done", done_cnt, start);
            scratch_i[5*32 +: 32] = 32'h0000_0077;
            wait (done_cnt == start + 1);
            @(negedge clk);
        end
        // R12 after refused words, a fresh command runs normally
        run_cmd(0, 32'h15, 32'h300, 32'h0, 32'h3, 32'hFFFF_FFFF, 0,
                '{32'h1, 32'h3});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule